// File: doc/BRIEF.md
# Nibble Register Clock Serial Slave

This block models the device side of a small calendar-clock part that is reached over a three-wire serial bus: a chip-enable, a host-driven clock and one bidirectional data line. While chip-enable is high the host shifts bytes in, most significant bit first. Each byte is decoded as one of three kinds of command. An address command selects one of sixteen 4-bit registers. A read command is an address command that also asks for the selected register to be shifted back. A data command stores its low nibble into the selected register. A byte that carries none of these flags has no effect.

The register file holds seconds, minutes, hours, weekday, day, month and year as units/tens nibble pairs, plus an interrupt-interval register, a control register and a test register. The block does not count time; every register simply holds what the host last wrote. The control register (address 0xE) has bit 0 as adjust/busy, bit 1 as write-enable/oscillator-stopped, bit 2 as the 12/24-hour select and bit 3 as a flag. An input lets a test environment force the busy bit as the host sees it, so that host polling loops can be exercised. A second read port lets a bench inspect any stored nibble directly.

All bus inputs are resynchronised to the block clock, so the host must hold each bus level for several block clocks. The serial host sets the pace of every transfer and the block has no way to stall it. For this reason the bus has no valid/ready handshake and no back-pressure.

Top module: `nibrtc_slave`

## Requirements
- R1: After reset every register reads 0 except the control register (address 0xE), which reads 4'b0010, and the data line is not driven (sda_oe low).
- R2: A received byte with bit 5 set latches bits 3..0 as the current register address. Bit 4 of such a byte is ignored and no register changes.
- R3: A received byte with bit 5 clear and bit 4 set writes bits 3..0 into the register at the current address.
- R4: A received byte with bits 5 and 4 both clear changes no register and no address.
- R5: A received byte with bits 6 and 5 set makes the block drive the 8-bit value {4'b0000, register nibble} MSB first. The first bit is driven before the next falling SCL edge, and each later bit follows a falling edge. The line is released after the eighth rising edge.
- R6: When busy_force is high, a read of the control register returns bit 0 as 1. The stored control nibble seen on the debug port is unchanged.
- R7: Chip-enable low discards a partially received byte, so bit counting restarts when chip-enable returns. It also ends a read and releases the data line.
- R8: SCL and SDA activity while chip-enable is low changes no register.
- R9: The register address latched by an address command survives chip-enable going low and high again.
- R10: Bytes are received MSB first, with each bit sampled on a rising SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Bus chip-enable, active high |
| scl | input | 1 | Serial clock driven by the host |
| sda_in | input | 1 | Serial data from the host |
| sda_out | output | 1 | Serial data driven back during a read |
| sda_oe | output | 1 | High while the block drives the data line |
| busy_force | input | 1 | Forces control bit 0 to 1 in read-back |
| dbg_addr | input | 4 | Register index for direct inspection |
| dbg_nib | output | 4 | Stored nibble at dbg_addr |

## Verification
The bench goes after the flag priority first. A byte that carries both the address flag and the data flag must only move the address; a decoder that tested bit 4 first would corrupt a register. It aborts a byte halfway through with chip-enable. A bit counter that survived the abort would merge the stale bits with the next byte and write the wrong register, or start a spurious read. It reads the control register with the busy flag forced and then checks the stored nibble. A design that wrote the forced bit back, or ignored it, shows up as a mismatch either in the serial value or on the debug port. It also drops chip-enable in the middle of a read and then keeps writing after the address latch has crossed a chip-enable gap. A design that kept driving the line would hold sda_oe high, and one that cleared the address would write register 0.

// File: rtl/nibrtc_pkg.sv
package nibrtc_pkg;
  localparam int NIB_W      = 4;
  localparam int REG_CNT    = 16;
  localparam int ADDR_W     = $clog2(REG_CNT);
  localparam int BYTE_W     = 8;
  localparam int FLAG_READ  = 6;
  localparam int FLAG_ADDR  = 5;
  localparam int FLAG_DATA  = 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 4'hE;
  localparam int                BUSY_BIT   = 0;
  localparam logic [NIB_W-1:0]  CTRL_RESET = 4'b0010;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_ADDR,
    CMD_READ,
    CMD_WRITE
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [BYTE_W-1:0] b);
    if (b[FLAG_ADDR]) return b[FLAG_READ] ? CMD_READ : CMD_ADDR;
    if (b[FLAG_DATA]) return CMD_WRITE;
    return CMD_NONE;
  endfunction
endpackage

// File: rtl/nibrtc_sync.sv
module nibrtc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nibrtc_serdes.sv
module nibrtc_serdes
  import nibrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              scl_fall,
  output logic              sda_out,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              scl_q;
  logic              scl_rise;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              rd_on;

  assign scl_rise  = ce_s & scl_s & ~scl_q;
  assign scl_fall  = ce_s & ~scl_s & scl_q;
  assign rx_byte   = {shreg[BYTE_W-2:0], sda_s};
  assign byte_done = scl_rise & ~rd_on & (cnt == LAST);
  assign sda_out   = rd_on & txreg[BYTE_W-1];
  assign sda_oe    = rd_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b0;
    else        scl_q <= scl_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
      txreg <= '0;
      rd_on <= 1'b0;
    end else if (!ce_s) begin
      cnt   <= '0;
      rd_on <= 1'b0;
      txreg <= '0;
    end else if (load) begin
      rd_on <= 1'b1;
      txreg <= load_byte;
      cnt   <= '0;
    end else if (rd_on) begin
      if (scl_fall) txreg <= {txreg[BYTE_W-2:0], 1'b0};
      if (scl_rise) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) rd_on <= 1'b0;
      end
    end else if (scl_rise) begin
      shreg <= rx_byte;
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nibrtc_regfile.sv
module nibrtc_regfile
  import nibrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NIB_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_bus,
  output logic [NIB_W-1:0]  rdata_bus,
  input  logic [ADDR_W-1:0] raddr_dbg,
  output logic [NIB_W-1:0]  rdata_dbg
);
  logic [NIB_W-1:0] regs [REG_CNT];

  generate
    for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
      localparam logic [NIB_W-1:0] RST_VAL =
        (r == int'(CTRL_ADDR)) ? CTRL_RESET : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[r] <= RST_VAL;
        else if (we && waddr == ADDR_W'(r)) regs[r] <= wdata;
      end
    end
  endgenerate

  assign rdata_bus = regs[raddr_bus];
  assign rdata_dbg = regs[raddr_dbg];
endmodule

// File: rtl/nibrtc_slave.sv
module nibrtc_slave
  import nibrtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce,
  input  logic                        scl,
  input  logic                        sda_in,
  output logic                        sda_out,
  output logic                        sda_oe,
  input  logic                        busy_force,
  input  logic [nibrtc_pkg::ADDR_W-1:0] dbg_addr,
  output logic [nibrtc_pkg::NIB_W-1:0]  dbg_nib
);
  logic [2:0]        bus_s;
  logic              ce_s, scl_s, sda_s;
  logic              byte_done, scl_fall, rd_load, rf_we;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] addr_q, rd_addr;
  logic [NIB_W-1:0]  bus_nib, rd_nib;
  cmd_e              cmd;

  nibrtc_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce, scl, sda_in}), .q(bus_s)
  );
  assign {ce_s, scl_s, sda_s} = bus_s;

  assign cmd     = decode_cmd(rx_byte);
  assign rf_we   = byte_done && cmd == CMD_WRITE;
  assign rd_load = byte_done && cmd == CMD_READ;
  assign rd_addr = rx_byte[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (byte_done && (cmd == CMD_ADDR || cmd == CMD_READ)) addr_q <= rd_addr;
  end

  always_comb begin
    rd_nib = bus_nib;
    if (rd_addr == CTRL_ADDR && busy_force) rd_nib[BUSY_BIT] = 1'b1;
  end

  nibrtc_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(addr_q), .wdata(rx_byte[NIB_W-1:0]),
    .raddr_bus(rd_addr), .rdata_bus(bus_nib),
    .raddr_dbg(dbg_addr), .rdata_dbg(dbg_nib)
  );

  nibrtc_serdes u_serdes (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .scl_s(scl_s), .sda_s(sda_s),
    .load(rd_load), .load_byte({{(BYTE_W-NIB_W){1'b0}}, rd_nib}),
    .byte_done(byte_done), .rx_byte(rx_byte), .scl_fall(scl_fall),
    .sda_out(sda_out), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/nibrtc_slave_chk.sv
module nibrtc_slave_chk
  import nibrtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              sda_oe,
  input logic              sda_out,
  input logic              scl_fall,
  input logic              byte_done,
  input logic              rf_we,
  input logic [ADDR_W-1:0] addr_q
);
  a_r7_release_on_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sda_oe);

  a_r5_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && $past(sda_oe) && !$stable(sda_out)) |-> $past(scl_fall));

  a_r5_upper_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !sda_out);

  a_r2_addr_moves_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(byte_done));

  a_r8_no_write_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ce_s);
endmodule

bind nibrtc_slave nibrtc_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sda_oe(sda_oe), .sda_out(sda_out),
  .scl_fall(scl_fall), .byte_done(byte_done), .rf_we(rf_we), .addr_q(addr_q)
);

// File: tb/test_nibrtc_slave.sv
module test_nibrtc_slave;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, scl = 1'b1, sda_in = 1'b0, busy_force = 1'b0;
  logic       sda_out, sda_oe;
  logic [3:0] dbg_addr = '0;
  logic [3:0] dbg_nib;

  int total = 0, bad = 0;
  bit done = 0;
  int mdl [16];
  int maddr = 0;

  always #2.5 clk = ~clk;

  nibrtc_slave i_nibrtc_slave (
    .clk(clk), .rst_n(rst_n), .ce(ce), .scl(scl), .sda_in(sda_in),
    .sda_out(sda_out), .sda_oe(sda_oe), .busy_force(busy_force),
    .dbg_addr(dbg_addr), .dbg_nib(dbg_nib)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_in = b[7-i];
      wait_n(H); scl = 1'b0;
      wait_n(H); scl = 1'b1;
      wait_n(H);
    end
  endtask

  // Behavioural model updated per complete byte
  task automatic host_byte(input logic [7:0] b);
    send_bits(b, 8);
    if (b[5]) maddr = int'(b[3:0]);
    else if (b[4]) mdl[maddr] = int'(b[3:0]);
  endtask

  task automatic read_back(input string req);
    logic [7:0] got;
    bit oes;
    int exp;
    exp = mdl[maddr];
    if (maddr == 14 && busy_force) exp = exp | 1;
    oes = 1;
    for (int i = 0; i < 8; i++) begin
      wait_n(H);
      got[7-i] = sda_out;
      oes &= sda_oe;
      scl = 1'b0; wait_n(H); scl = 1'b1;
    end
    chk(got == 8'(exp) && oes, req, int'(got), exp);
    wait_n(2*H);
    chk(!sda_oe, {req, " release"}, int'(sda_oe), 0);
  endtask

  task automatic check_regs(input string req);
    bit ok = 1;
    for (int a = 0; a < 16; a++) begin
      dbg_addr = 4'(a);
      wait_n(1);
      if (int'(dbg_nib) != mdl[a]) begin
        ok = 0;
        $display("FAIL %s reg%0d actual=%0h expected=%0h", req, a, dbg_nib, mdl[a]);
      end
    end
    total++;
    if (!ok) bad++;
  endtask

  task automatic ce_up;   ce = 1'b1; wait_n(H); endtask
  task automatic ce_down; wait_n(H); ce = 1'b0; wait_n(H); endtask

  initial begin
    for (int a = 0; a < 16; a++) mdl[a] = 0;
    mdl[14] = 2;
    wait_n(4); rst_n = 1'b1; wait_n(4);
    check_regs("R1 reset values");
    chk(!sda_oe, "R1 line idle", int'(sda_oe), 0);

    ce_up();
    host_byte(8'h23); host_byte(8'h19);
    check_regs("R3 write reg3");
    host_byte(8'h35);              // R2 address with data flag
    check_regs("R2 no write on address byte");
    host_byte(8'h1A);
    check_regs("R10 msb-first write reg5");
    host_byte(8'h65); read_back("R5 read reg5");
    host_byte(8'h0C);
    check_regs("R4 flagless byte ignored");
    host_byte(8'h63); read_back("R5 read reg3");

    host_byte(8'h2E); host_byte(8'h14);
    busy_force = 1'b1;
    host_byte(8'h6E); read_back("R6 busy forced read");
    check_regs("R6 stored control kept");
    busy_force = 1'b0;
    host_byte(8'h6E); read_back("R6 busy released read");

    host_byte(8'h21);
    send_bits(8'hF0, 4);           // R7 partial byte
    ce_down(); ce_up();
    host_byte(8'h17);
    check_regs("R7 partial byte discarded");

    ce_down();
    send_bits(8'h1C, 8);           // R8 activity while disabled
    check_regs("R8 ignored while disabled");
    ce_up();
    host_byte(8'h13);
    check_regs("R9 address kept across disable");

    host_byte(8'h65);
    wait_n(3*H);
    ce_down();
    chk(!sda_oe, "R7 read aborted", int'(sda_oe), 0);
    ce_up();
    host_byte(8'h2F); host_byte(8'h1B);
    host_byte(8'h6F); read_back("R5 read test register");
    check_regs("R3 final registers");
    ce_down();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule